// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a tree of descriptors from memory. The tree's root is a table of 8-byte entries, addressed from a root base input. The next two levels are tables of 4-byte entries. A requester presents an address, a write flag and a supervisor flag. The walker then issues descriptor reads over a single-outstanding memory port and returns either a physical address or a fault code.

Every descriptor carries a two-bit type code in bits 1:0, and that code decides what happens at each step:
- 00 is an invalid entry.
- 01 is a page.
- 10 points to a 4-byte-entry table.
- 11 points to an 8-byte-entry table.

Because the lower levels are fixed at 4-byte entries, type 11 is never a valid descent. A page type can end the walk at any of the three levels, and any address bits that were not consumed as an index are then added to the page frame.

After a successful walk, and before answering, the walker writes back descriptors whose used flag (bit 3) was clear. On a write access it also sets the modified flag (bit 4) in the page descriptor. A walk that faults writes nothing to memory.

Top module: `xlate_walker`

## Requirements
- R1: After reset, req_ready is 1, and rsp_valid and mem_valid are 0.
- R2: Descriptor reads follow a fixed address pattern:
  - The first read is at {root_base[31:4],4'b0} + va[31:25]×8 and returns the attribute word. The next read is at that address + 4 and returns the pointer word.
  - A table pointer's base is bits 31:4 of the pointer word, with the low four bits zero.
  - The second level is read at base + va[24:19]×4 and the third level at base + va[18:13]×4.
- R3: A page descriptor (type 01) at the third level gives rsp_paddr = {page[31:13], va[12:0]}. Bits 12:8 of the page word are ignored.
- R4: A page at the first level gives rsp_paddr = {page[31:13],13'b0} + va[24:0]. A page at the second level gives {page[31:13],13'b0} + va[18:0].
- R5: The walk stops with rsp_fault = 01 (invalid) in three cases:
  - type 00 at any level;
  - type 11 at the first or second level;
  - any type other than 01 at the third level.
- R6: A write access that meets a descriptor with bit 2 (write-protect) set returns rsp_fault = 10 (protection).
- R7: A user access (req_super = 0) whose first-level attribute word has bit 8 set returns rsp_fault = 11 (privilege). This is checked before write-protect.
- R8: A faulting walk performs no memory write and stops reading at the faulting descriptor. rsp_paddr is 0 on a fault.
- R9: On success, every visited descriptor word whose bit 3 is clear is rewritten at its own address with bit 3 set. The writes go in level order, before the response. Words that already have the bit set are not written.
- R10: A successful write access also sets bit 4 of the page descriptor word. For a first-level page this is the attribute word.
- R11: req_ready is high only while idle. Each accepted request gets exactly one single-cycle rsp_valid, with rsp_fault = 00 on success.
- R12: A memory request keeps mem_addr, mem_write and mem_wdata unchanged until mem_done is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| root_base | input | 32 | Base address of the first-level table |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted when both high |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_super | input | 1 | Access is from supervisor mode |
| mem_valid | output | 1 | Memory access request, held until done |
| mem_write | output | 1 | Access is a descriptor write-back |
| mem_addr | output | 32 | Descriptor address |
| mem_wdata | output | 32 | Updated descriptor word |
| mem_done | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Descriptor word read |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_paddr | output | 32 | Physical address |
| rsp_fault | output | 2 | 00 ok, 01 invalid, 10 protection, 11 privilege |

## Verification
Some properties are checked on every cycle:
- the memory request holds steady while it waits;
- the response lasts exactly one cycle;
- the walker does not accept a new request while busy;
- every write-back carries the used flag;
- no write has happened during a walk that ends in a fault.

The bench's behavioural model covers the rest. It predicts the exact sequence of descriptor addresses and updated words, and the walk depth, fault priority and physical-address arithmetic. These can only be shown by scenarios built over a prepared descriptor tree.

// File: rtl/xw_pkg.sv
`timescale 1ns/1ps
package xw_pkg;

    localparam int unsigned XW_DW       = 32;
    localparam int unsigned XW_WP_BIT   = 2;
    localparam int unsigned XW_USED_BIT = 3;
    localparam int unsigned XW_MOD_BIT  = 4;
    localparam int unsigned XW_SUPV_BIT = 8;

    // Type code in descriptor bits 1:0
    typedef enum logic [1:0] {
        DT_INVALID = 2'b00,
        DT_PAGE    = 2'b01,
        DT_SHORT   = 2'b10,
        DT_LONG    = 2'b11
    } dtype_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'b00,
        FLT_INVALID = 2'b01,
        FLT_PROT    = 2'b10,
        FLT_PRIV    = 2'b11
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WBACK,
        ST_RESP
    } state_e;

    // Which descriptor word the current fetch reads
    typedef enum logic [1:0] {
        STEP_L1_ATTR,
        STEP_L1_PTR,
        STEP_L2,
        STEP_L3
    } step_e;

    typedef struct packed {
        dtype_e             dtype;
        logic               wprot;
        logic               supv;
        logic [XW_DW-1:0]   tbl_base;
        logic [XW_DW-1:0]   page_base;
    } desc_t;

endpackage

// File: rtl/xw_desc_decode.sv
`timescale 1ns/1ps
module xw_desc_decode
    import xw_pkg::*;
(
    input  logic [XW_DW-1:0] word_i,
    output desc_t            desc_o
);

    always_comb begin
        desc_o.dtype     = dtype_e'(word_i[1:0]);
        desc_o.wprot     = word_i[XW_WP_BIT];
        desc_o.supv      = word_i[XW_SUPV_BIT];
        desc_o.tbl_base  = {word_i[XW_DW-1:4], 4'b0000};
        desc_o.page_base = {word_i[XW_DW-1:8], 8'h00};
    end

    // Used and modified flags are handled by the write-back path in the top
    logic unused_flags;
    assign unused_flags = ^{word_i[XW_MOD_BIT], word_i[XW_USED_BIT]};

endmodule

// File: rtl/xw_entry_addr.sv
`timescale 1ns/1ps
module xw_entry_addr
    import xw_pkg::*;
#(
    parameter int unsigned IDX_A_W = 7,
    parameter int unsigned IDX_B_W = 6,
    parameter int unsigned IDX_C_W = 6,
    parameter int unsigned OFF_W   = 13
) (
    input  logic [IDX_A_W+IDX_B_W+IDX_C_W+OFF_W-1:0] vaddr_i,
    input  logic [XW_DW-1:0]                          base_i,
    input  step_e                                     step_i,
    output logic [XW_DW-1:0]                          addr_o
);

    localparam int unsigned C_LSB = OFF_W;
    localparam int unsigned B_LSB = C_LSB + IDX_C_W;
    localparam int unsigned A_LSB = B_LSB + IDX_B_W;

    logic [IDX_A_W-1:0] idx_a;
    logic [IDX_B_W-1:0] idx_b;
    logic [IDX_C_W-1:0] idx_c;

    assign idx_a = vaddr_i[A_LSB +: IDX_A_W];
    assign idx_b = vaddr_i[B_LSB +: IDX_B_W];
    assign idx_c = vaddr_i[C_LSB +: IDX_C_W];

    // First level: 8-byte entries, attribute word then pointer word.
    // Lower levels: 4-byte entries.
    always_comb begin
        unique case (step_i)
            STEP_L1_ATTR: addr_o = base_i + (XW_DW'(idx_a) << 3);
            STEP_L1_PTR:  addr_o = base_i + (XW_DW'(idx_a) << 3) + XW_DW'(4);
            STEP_L2:      addr_o = base_i + (XW_DW'(idx_b) << 2);
            default:      addr_o = base_i + (XW_DW'(idx_c) << 2);
        endcase
    end

    logic unused_offset;
    assign unused_offset = ^vaddr_i[OFF_W-1:0];

endmodule

// File: rtl/xw_pa_calc.sv
`timescale 1ns/1ps
module xw_pa_calc
    import xw_pkg::*;
#(
    parameter int unsigned IDX_A_W = 7,
    parameter int unsigned IDX_B_W = 6,
    parameter int unsigned IDX_C_W = 6,
    parameter int unsigned OFF_W   = 13
) (
    input  logic [XW_DW-1:0]                          page_base_i,
    input  logic [IDX_A_W+IDX_B_W+IDX_C_W+OFF_W-1:0] vaddr_i,
    input  logic [1:0]                                level_i,
    output logic [XW_DW-1:0]                          paddr_o
);

    localparam int unsigned VA_W  = IDX_A_W + IDX_B_W + IDX_C_W + OFF_W;
    localparam int unsigned B_LSB = OFF_W + IDX_C_W;
    localparam int unsigned A_LSB = B_LSB + IDX_B_W;

    logic [XW_DW-1:0] frame;
    logic [XW_DW-1:0] keep;

    assign frame = {page_base_i[XW_DW-1:OFF_W], {OFF_W{1'b0}}};

    // Index bits not consumed by the walk stay part of the in-page offset
    always_comb begin
        unique case (level_i)
            2'd1:    keep = (XW_DW'(1) << A_LSB) - XW_DW'(1);
            2'd2:    keep = (XW_DW'(1) << B_LSB) - XW_DW'(1);
            default: keep = (XW_DW'(1) << OFF_W) - XW_DW'(1);
        endcase
    end

    assign paddr_o = frame + (XW_DW'(vaddr_i) & keep);

    logic unused_low;
    assign unused_low = ^page_base_i[OFF_W-1:0];

endmodule

// File: rtl/xlate_walker.sv
`timescale 1ns/1ps
module xlate_walker
    import xw_pkg::*;
#(
    parameter int unsigned IDX_A_W = 7,
    parameter int unsigned IDX_B_W = 6,
    parameter int unsigned IDX_C_W = 6,
    parameter int unsigned OFF_W   = 13
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [31:0]                               root_base,
    input  logic                                      req_valid,
    output logic                                      req_ready,
    input  logic [IDX_A_W+IDX_B_W+IDX_C_W+OFF_W-1:0] req_vaddr,
    input  logic                                      req_write,
    input  logic                                      req_super,
    output logic                                      mem_valid,
    output logic                                      mem_write,
    output logic [31:0]                               mem_addr,
    output logic [31:0]                               mem_wdata,
    input  logic                                      mem_done,
    input  logic [31:0]                               mem_rdata,
    output logic                                      rsp_valid,
    output logic [31:0]                               rsp_paddr,
    output logic [1:0]                                rsp_fault
);

    localparam int unsigned VA_W = IDX_A_W + IDX_B_W + IDX_C_W + OFF_W;
    localparam logic [XW_DW-1:0] USED_MASK = XW_DW'(1) << XW_USED_BIT;
    localparam logic [XW_DW-1:0] MOD_MASK  = XW_DW'(1) << XW_MOD_BIT;

    typedef struct packed {
        state_e           state;
        step_e            step;
        logic [VA_W-1:0]  vaddr;
        logic             wr;
        logic             sup;
        logic [XW_DW-1:0] tbl_base;
        logic [XW_DW-1:0] page_base;
        logic [1:0]       end_lvl;
        logic [1:0]       wb_lvl;
        logic [XW_DW-1:0] d1;
        logic [XW_DW-1:0] a1;
        logic [XW_DW-1:0] d2;
        logic [XW_DW-1:0] a2;
        logic [XW_DW-1:0] d3;
        logic [XW_DW-1:0] a3;
        fault_e           fault;
    } walk_t;

    walk_t r_q, r_d;

    // ---------------- helpers ----------------
    logic [XW_DW-1:0] entry_addr;
    desc_t            dec;
    logic [XW_DW-1:0] pa_calc;

    xw_entry_addr #(
        .IDX_A_W (IDX_A_W),
        .IDX_B_W (IDX_B_W),
        .IDX_C_W (IDX_C_W),
        .OFF_W   (OFF_W)
    ) u_ea (
        .vaddr_i (r_q.vaddr),
        .base_i  (r_q.tbl_base),
        .step_i  (r_q.step),
        .addr_o  (entry_addr)
    );

    xw_desc_decode u_dec (
        .word_i (mem_rdata),
        .desc_o (dec)
    );

    xw_pa_calc #(
        .IDX_A_W (IDX_A_W),
        .IDX_B_W (IDX_B_W),
        .IDX_C_W (IDX_C_W),
        .OFF_W   (OFF_W)
    ) u_pa (
        .page_base_i (r_q.page_base),
        .vaddr_i     (r_q.vaddr),
        .level_i     (r_q.end_lvl),
        .paddr_o     (pa_calc)
    );

    // ---------------- write-back selection ----------------
    logic [XW_DW-1:0] wb_old;
    logic [XW_DW-1:0] wb_addr;
    logic [XW_DW-1:0] wb_word;
    logic             wb_need;

    always_comb begin
        unique case (r_q.wb_lvl)
            2'd1: begin
                wb_old  = r_q.d1;
                wb_addr = r_q.a1;
            end
            2'd2: begin
                wb_old  = r_q.d2;
                wb_addr = r_q.a2;
            end
            default: begin
                wb_old  = r_q.d3;
                wb_addr = r_q.a3;
            end
        endcase
        wb_word = wb_old | USED_MASK;
        if ((r_q.wb_lvl == r_q.end_lvl) && r_q.wr) begin
            wb_word = wb_word | MOD_MASK;
        end
        wb_need = (wb_word != wb_old);
    end

    // ---------------- outputs ----------------
    always_comb begin
        req_ready = (r_q.state == ST_IDLE);
        mem_valid = (r_q.state == ST_FETCH) || ((r_q.state == ST_WBACK) && wb_need);
        mem_write = (r_q.state == ST_WBACK);
        mem_addr  = (r_q.state == ST_WBACK) ? wb_addr : entry_addr;
        mem_wdata = (r_q.state == ST_WBACK) ? wb_word : '0;
        rsp_valid = (r_q.state == ST_RESP);
        rsp_fault = r_q.fault;
        rsp_paddr = ((r_q.state == ST_RESP) && (r_q.fault == FLT_NONE)) ? pa_calc : '0;
    end

    // ---------------- next state ----------------
    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.vaddr    = req_vaddr;
                    r_d.wr       = req_write;
                    r_d.sup      = req_super;
                    r_d.tbl_base = {root_base[31:4], 4'b0000};
                    r_d.step     = STEP_L1_ATTR;
                    r_d.fault    = FLT_NONE;
                    r_d.end_lvl  = 2'd3;
                    r_d.wb_lvl   = 2'd1;
                    r_d.state    = ST_FETCH;
                end
            end

            ST_FETCH: begin
                if (mem_done) begin
                    unique case (r_q.step)
                        STEP_L1_ATTR: begin
                            r_d.d1 = mem_rdata;
                            r_d.a1 = entry_addr;
                            if ((dec.dtype == DT_INVALID) || (dec.dtype == DT_LONG)) begin
                                r_d.fault = FLT_INVALID;
                                r_d.state = ST_RESP;
                            end else if (!r_q.sup && dec.supv) begin
                                r_d.fault = FLT_PRIV;
                                r_d.state = ST_RESP;
                            end else if (r_q.wr && dec.wprot) begin
                                r_d.fault = FLT_PROT;
                                r_d.state = ST_RESP;
                            end else begin
                                r_d.step = STEP_L1_PTR;
                            end
                        end

                        STEP_L1_PTR: begin
                            if (dtype_e'(r_q.d1[1:0]) == DT_PAGE) begin
                                r_d.page_base = dec.page_base;
                                r_d.end_lvl   = 2'd1;
                                r_d.state     = ST_WBACK;
                            end else begin
                                r_d.tbl_base = dec.tbl_base;
                                r_d.step     = STEP_L2;
                            end
                        end

                        STEP_L2: begin
                            r_d.d2 = mem_rdata;
                            r_d.a2 = entry_addr;
                            if ((dec.dtype == DT_INVALID) || (dec.dtype == DT_LONG)) begin
                                r_d.fault = FLT_INVALID;
                                r_d.state = ST_RESP;
                            end else if (r_q.wr && dec.wprot) begin
                                r_d.fault = FLT_PROT;
                                r_d.state = ST_RESP;
                            end else if (dec.dtype == DT_PAGE) begin
                                r_d.page_base = dec.page_base;
                                r_d.end_lvl   = 2'd2;
                                r_d.state     = ST_WBACK;
                            end else begin
                                r_d.tbl_base = dec.tbl_base;
                                r_d.step     = STEP_L3;
                            end
                        end

                        default: begin
                            r_d.d3 = mem_rdata;
                            r_d.a3 = entry_addr;
                            if (dec.dtype != DT_PAGE) begin
                                r_d.fault = FLT_INVALID;
                                r_d.state = ST_RESP;
                            end else if (r_q.wr && dec.wprot) begin
                                r_d.fault = FLT_PROT;
                                r_d.state = ST_RESP;
                            end else begin
                                r_d.page_base = dec.page_base;
                                r_d.end_lvl   = 2'd3;
                                r_d.state     = ST_WBACK;
                            end
                        end
                    endcase
                end
            end

            ST_WBACK: begin
                if (!wb_need || mem_done) begin
                    if (r_q.wb_lvl == r_q.end_lvl) begin
                        r_d.state = ST_RESP;
                    end else begin
                        r_d.wb_lvl = r_q.wb_lvl + 2'd1;
                    end
                end
            end

            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, step: STEP_L1_ATTR, fault: FLT_NONE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    // ---------------- assertions ----------------
    logic wrote_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wrote_q <= 1'b0;
        end else if (req_valid && req_ready) begin
            wrote_q <= 1'b0;
        end else if (mem_valid && mem_write && mem_done) begin
            wrote_q <= 1'b1;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_valid && !rsp_valid));

    p_no_write_on_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_fault != 2'b00)) |-> !wrote_q);

    p_wb_sets_used_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_write) |-> mem_wdata[XW_USED_BIT]);

    p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_done) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)));

endmodule

// File: tb/xlate_walker_test.sv
`timescale 1ns/1ps
module xlate_walker_test;

    localparam logic [31:0] ROOT = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] root_base = ROOT;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_super = 1'b0;
    logic        mem_valid;
    logic        mem_write;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_done = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;

    always #2.5 clk = ~clk;

    xlate_walker uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .root_base (root_base),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_vaddr (req_vaddr),
        .req_write (req_write),
        .req_super (req_super),
        .mem_valid (mem_valid),
        .mem_write (mem_write),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_done  (mem_done),
        .mem_rdata (mem_rdata),
        .rsp_valid (rsp_valid),
        .rsp_paddr (rsp_paddr),
        .rsp_fault (rsp_fault)
    );

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
    } acc_t;

    acc_t        exp_q[$];
    logic [31:0] mem [int unsigned];
    int          extra_wait = 0;
    int          wait_cnt = 0;
    logic [31:0] held_addr = '0;
    string       wtag = "R9";

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic logic [31:0] mkva(input logic [6:0] a, input logic [5:0] b,
                                         input logic [5:0] c, input logic [12:0] off);
        return {a, b, c, off};
    endfunction

    task automatic put_long(input logic [6:0] idx, input logic [31:0] attr, input logic [31:0] ptr);
        mem[ROOT + {22'd0, idx, 3'd0}]          = attr;
        mem[ROOT + {22'd0, idx, 3'd0} + 32'd4]  = ptr;
    endtask

    task automatic put_short(input logic [31:0] base, input logic [5:0] idx, input logic [31:0] val);
        mem[base + {24'd0, idx, 2'd0}] = val;
    endtask

    // Behavioural reference: predicts accesses, fault code and address
    task automatic model(input logic [31:0] va, input bit wr, input bit sup,
                         output logic [1:0] f, output logic [31:0] pa);
        logic [31:0] vis_a[3];
        logic [31:0] vis_w[3];
        int          n;
        logic [31:0] a, w, p, base, keep;
        logic [1:0]  t;
        f = 2'b00; pa = '0; n = 0; base = '0; keep = '0;
        a = ROOT + {22'd0, va[31:25], 3'd0};
        w = rd(a);
        exp_q.push_back('{1'b0, a, 32'h0});
        t = w[1:0];
        if (t == 2'b00 || t == 2'b11) begin f = 2'b01; return; end
        if (!sup && w[8]) begin f = 2'b11; return; end
        if (wr && w[2]) begin f = 2'b10; return; end
        vis_a[0] = a; vis_w[0] = w; n = 1;
        p = rd(a + 32'd4);
        exp_q.push_back('{1'b0, a + 32'd4, 32'h0});
        if (t == 2'b01) begin
            base = p; keep = 32'h01FF_FFFF;
        end else begin
            a = (p & ~32'hF) + {24'd0, va[24:19], 2'd0};
            w = rd(a);
            exp_q.push_back('{1'b0, a, 32'h0});
            t = w[1:0];
            if (t == 2'b00 || t == 2'b11) begin f = 2'b01; return; end
            if (wr && w[2]) begin f = 2'b10; return; end
            vis_a[1] = a; vis_w[1] = w; n = 2;
            if (t == 2'b01) begin
                base = w; keep = 32'h0007_FFFF;
            end else begin
                a = (w & ~32'hF) + {24'd0, va[18:13], 2'd0};
                w = rd(a);
                exp_q.push_back('{1'b0, a, 32'h0});
                t = w[1:0];
                if (t != 2'b01) begin f = 2'b01; return; end
                if (wr && w[2]) begin f = 2'b10; return; end
                vis_a[2] = a; vis_w[2] = w; n = 3;
                base = w; keep = 32'h0000_1FFF;
            end
        end
        pa = (base & 32'hFFFF_E000) + (va & keep);
        for (int i = 0; i < n; i++) begin
            logic [31:0] nw;
            nw = vis_w[i] | 32'h8;
            if (i == n - 1 && wr) nw = nw | 32'h10;
            if (nw != vis_w[i]) exp_q.push_back('{1'b1, vis_a[i], nw});
        end
    endtask

    // Memory: one access served per request, compared against the model
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_done = 1'b0;
            wait_cnt = 0;
        end else if (mem_done) begin
            mem_done = 1'b0;
        end else if (mem_valid) begin
            if (wait_cnt == 0) held_addr = mem_addr;
            else chk(mem_addr == held_addr, "R12", "request held while waiting", mem_addr, held_addr);
            if (wait_cnt < extra_wait) begin
                wait_cnt++;
            end else begin
                wait_cnt = 0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected memory access", mem_addr, 32'h0);
                end else begin
                    acc_t e;
                    e = exp_q.pop_front();
                    chk(mem_write == e.we && mem_addr == e.addr && (!e.we || mem_wdata == e.data),
                        e.we ? wtag : "R2", e.we ? "descriptor write-back" : "descriptor read",
                        e.we ? mem_wdata : mem_addr, e.we ? e.data : e.addr);
                end
                if (mem_write) mem[mem_addr] = mem_wdata;
                else mem_rdata = rd(mem_addr);
                mem_done = 1'b1;
            end
        end
    end

    task automatic walk(input logic [31:0] va, input bit wr, input bit sup, input string tag);
        logic [1:0]  ef;
        logic [31:0] epa;
        model(va, wr, sup, ef, epa);
        wtag = tag;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr; req_super = sup;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R11", "busy after accept", {31'd0, req_ready}, 32'd0);
        while (!rsp_valid) @(negedge clk);
        chk(rsp_fault == ef, tag, "fault code", {30'd0, rsp_fault}, {30'd0, ef});
        chk(rsp_paddr == epa, tag, "physical address", rsp_paddr, epa);
        chk(exp_q.size() == 0, "R8", "all expected accesses done", exp_q.size(), 32'd0);
        exp_q.delete();
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R11", "single-cycle response", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // Descriptor tree
        put_long(7'd5, 32'h0000_0002, 32'h0002_0000);
        put_short(32'h0002_0000, 6'h3F, 32'h0003_0002);
        put_short(32'h0003_0000, 6'h21, 32'h1234_5F01);
        put_long(7'd6, 32'h0000_0001, 32'h4000_0000);
        put_long(7'd7, 32'h0000_0002, 32'h0002_0100);
        put_short(32'h0002_0100, 6'd2, 32'h5000_0001);
        put_long(7'd8, 32'h0000_0000, 32'h0002_0000);
        put_long(7'd9, 32'h0000_0003, 32'h0002_0000);
        put_long(7'd10, 32'h0000_0002, 32'h0002_0200);
        put_short(32'h0002_0200, 6'd1, 32'h0000_0000);
        put_short(32'h0002_0200, 6'd4, 32'h0003_0102);
        put_short(32'h0003_0100, 6'd0, 32'h0003_0202);
        put_short(32'h0003_0100, 6'd1, 32'h6000_0005);
        put_short(32'h0002_0200, 6'd5, 32'h0003_0206);
        put_short(32'h0003_0200, 6'd3, 32'h7000_0001);
        put_long(7'd11, 32'h0000_0106, 32'h0002_0300);
        put_short(32'h0002_0300, 6'd0, 32'h7100_0001);
        put_long(7'd12, 32'h0000_0002, 32'h0002_0400);
        put_short(32'h0002_0400, 6'd0, 32'h0003_0302);
        put_short(32'h0003_0300, 6'd0, 32'h7200_0009);

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1", "ready in reset", {31'd0, req_ready}, 32'd1);
        chk(rsp_valid == 1'b0, "R1", "no response in reset", {31'd0, rsp_valid}, 32'd0);
        chk(mem_valid == 1'b0, "R1", "no memory access in reset", {31'd0, mem_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && mem_valid == 1'b0, "R1", "idle after reset",
            {30'd0, req_ready, mem_valid}, 32'd2);

        // R3, R2, R9: full walk, used flags set on all three levels
        walk(mkva(7'd5, 6'h3F, 6'h21, 13'h0ABC), 1'b0, 1'b0, "R3");
        // R9: flags already set, no write-back
        walk(mkva(7'd5, 6'h3F, 6'h21, 13'h1FFF), 1'b0, 1'b0, "R9");
        // R10: write sets modified in the third-level page
        walk(mkva(7'd5, 6'h3F, 6'h21, 13'h0001), 1'b1, 1'b0, "R10");
        // R4, R10: page at the first level, write
        walk(mkva(7'd6, 6'h15, 6'h2A, 13'h1234), 1'b1, 1'b1, "R4");
        // R4, R12: page at the second level with a slow memory
        extra_wait = 3;
        walk(mkva(7'd7, 6'd2, 6'h3F, 13'h1FFF), 1'b0, 1'b0, "R12");
        extra_wait = 0;
        // R5, R8: invalid descriptors at each level
        walk(mkva(7'd8, 6'd0, 6'd0, 13'h0), 1'b0, 1'b1, "R5");
        walk(mkva(7'd9, 6'd0, 6'd0, 13'h0), 1'b0, 1'b1, "R5");
        walk(mkva(7'd10, 6'd1, 6'd0, 13'h0), 1'b0, 1'b1, "R5");
        walk(mkva(7'd10, 6'd4, 6'd0, 13'h0), 1'b1, 1'b1, "R5");
        // R6: write-protect on the page, then on a second-level table
        walk(mkva(7'd10, 6'd4, 6'd1, 13'h10), 1'b0, 1'b1, "R6");
        walk(mkva(7'd10, 6'd4, 6'd1, 13'h10), 1'b1, 1'b1, "R6");
        walk(mkva(7'd10, 6'd5, 6'd3, 13'h20), 1'b1, 1'b0, "R6");
        walk(mkva(7'd10, 6'd5, 6'd3, 13'h20), 1'b0, 1'b0, "R6");
        // R7: supervisor-only first-level entry
        walk(mkva(7'd11, 6'd0, 6'd7, 13'h44), 1'b0, 1'b0, "R7");
        walk(mkva(7'd11, 6'd0, 6'd7, 13'h44), 1'b1, 1'b0, "R7");
        walk(mkva(7'd11, 6'd0, 6'd7, 13'h44), 1'b1, 1'b1, "R7");
        walk(mkva(7'd11, 6'd0, 6'd7, 13'h44), 1'b0, 1'b1, "R7");
        // R10: used already set, write adds modified only
        walk(mkva(7'd12, 6'd0, 6'd0, 13'h100), 1'b1, 1'b0, "R10");
        // R11: back-to-back requests
        walk(mkva(7'd12, 6'd0, 6'd0, 13'h101), 1'b1, 1'b0, "R11");
        walk(mkva(7'd6, 6'h01, 6'h02, 13'h3), 1'b0, 1'b0, "R11");

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule